// File: doc/BRIEF.md
# Three-Channel Gamma Lookup Stage

This block applies a per-channel gamma curve to 8-bit RGB pixels for three display channels. All nine curves (red, green and blue for each channel) live in one flat on-chip table memory. A host fills that memory through two registers. The first is an address register, which carries a pointer and an auto-increment flag. The second is a data register: each write to it stores one table entry.

Each channel has its own pixel stream with a valid strobe. When the channel's gamma enable is set, each of the three components is replaced by its entry in that channel's table. When the enable is clear, the components pass through unchanged. Both paths take one clock.

The table memory is treated as powered down whenever no channel has gamma enabled, and its contents are then considered lost. A per-channel fill tracker records whether a full reload has happened since the memory last powered up. A lookup made before that reload raises a per-pixel error flag.

A power state machine has the states MEM_OFF and MEM_ON. It goes from MEM_OFF to MEM_ON when any enable is set, and from MEM_ON to MEM_OFF when all enables are clear.

Each channel's fill tracker has the states FILL_STALE, FILL_LOADING and FILL_READY, with these transitions:
- FILL_STALE to FILL_LOADING on the first data write into the channel's region.
- FILL_LOADING to FILL_READY on the 768th such write.
- Any state to FILL_STALE whenever the power machine is heading to, or staying in, MEM_OFF.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset no output is valid, no error is flagged, every channel is stale, and the power state is MEM_OFF.
- R2: The table entry for channel c (0..2), colour k (0 red, 1 green, 2 blue) and input value i sits at address c*768 + k*256 + i.
- R3: A host write with host_sel=0 loads the address from host_wdata[14:0] and the auto-increment flag from host_wdata[15]. An address value above 2303 is replaced by 0.
- R4: A host write with host_sel=1 while the memory is on stores host_wdata[7:0] at the current address. If auto-increment is set, the address then advances by one.
- R5: An auto-incremented address at 2303 wraps to 0.
- R6: With auto-increment clear, repeated data writes overwrite the same entry and the address does not move.
- R7: A pixel accepted with gamma enabled appears one cycle later with each component replaced by its table entry. The pixel on pix_in[c*24 +: 24] carries red in [23:16], green in [15:8] and blue in [7:0]. The three components and the valid strobe stay aligned, and channels are processed in parallel.
- R8: A pixel accepted with gamma disabled appears one cycle later unchanged, with no error flag.
- R9: When all gamma enables are clear, every channel returns to stale and data writes are ignored. A later lookup is flagged as an error until that channel is reloaded.
- R10: A channel becomes ready after 768 data writes into its own region since the memory last powered on. A lookup made with gamma enabled on a channel that is not ready raises pix_err_out for that pixel. An error is never raised without an accepted pixel that has gamma enabled.
- R11: Loading one channel's region does not make any other channel ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the address register, 1 the data register |
| host_wdata | input | 16 | Host write data |
| gamma_en | input | 3 | Per-channel gamma enable |
| pix_valid_in | input | 3 | Per-channel input pixel valid |
| pix_in | input | 72 | Per-channel RGB input pixels, 24 bits each |
| pix_valid_out | output | 3 | Per-channel output pixel valid |
| pix_out | output | 72 | Per-channel RGB output pixels |
| pix_err_out | output | 3 | Per-channel lookup-on-invalid-table flag |

## Verification
A host register write takes effect at the clock edge that samples it. A change of gamma_en reaches the power state at the next edge, so the bench waits two cycles before relying on the new state. Pixel results, including the error flag, are due exactly one edge after the edge that accepts the pixel. The bench therefore drives every input on a falling edge and reads the outputs at the following falling edge, after exactly one rising edge has passed. Expected table contents come from a bench-side model of the address arithmetic: the layout, the increment, the wrap and the out-of-range reset.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int DEF_NUM_CH = 3;
    localparam int DEF_COMP_W = 8;
    localparam int DEF_HOST_W = 16;
    localparam int COLOURS    = 3;

    typedef enum logic {
        MEM_OFF,
        MEM_ON
    } mem_pwr_e;

    typedef enum logic [1:0] {
        FILL_STALE,
        FILL_LOADING,
        FILL_READY
    } fill_e;
endpackage

// File: rtl/gamma_host_port.sv
module gamma_host_port #(
    parameter int MEM_DEPTH = 2304,
    parameter int ADDR_W    = 12,
    parameter int HOST_W    = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              mem_on,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int INC_BIT = HOST_W - 1;
    localparam int FIELD_W = HOST_W - 1;
    localparam logic [FIELD_W-1:0] FIELD_LAST = FIELD_W'(MEM_DEPTH - 1);
    localparam logic [ADDR_W-1:0]  ADDR_LAST  = ADDR_W'(MEM_DEPTH - 1);

    logic [ADDR_W-1:0]  addr_q;
    logic               inc_q;
    logic [FIELD_W-1:0] addr_field;

    assign addr_field = host_wdata[FIELD_W-1:0];
    assign wr_fire    = host_wr && host_sel && mem_on;
    assign wr_addr    = addr_q;
    assign wr_data    = host_wdata[DATA_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            inc_q  <= 1'b0;
        end else if (host_wr && !host_sel) begin
            inc_q  <= host_wdata[INC_BIT];
            addr_q <= (addr_field > FIELD_LAST) ? '0 : addr_field[ADDR_W-1:0];
        end else if (wr_fire && inc_q) begin
            addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
        end
    end
endmodule

// File: rtl/gamma_fill_tracker.sv
module gamma_fill_tracker
    import gamma_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int CH_SPAN = 768,
    parameter int BASE    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_drop,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ready
);
    localparam int CNT_W = $clog2(CH_SPAN);
    localparam logic [ADDR_W:0]  LO       = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0]  SPAN     = (ADDR_W+1)'(CH_SPAN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CH_SPAN - 1);

    fill_e            st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ADDR_W:0]  offs;
    logic             hit;

    // Offset wraps to a large value for addresses below the base.
    assign offs = {1'b0, wr_addr} - LO;
    assign hit  = wr_fire && (offs < SPAN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FILL_STALE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (pwr_drop) begin
            st_d  = FILL_STALE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                FILL_STALE: begin
                    if (hit) begin
                        st_d  = FILL_LOADING;
                        cnt_d = CNT_W'(1);
                    end
                end
                FILL_LOADING: begin
                    if (hit) begin
                        if (cnt_q == LAST_CNT) st_d = FILL_READY;
                        else                   cnt_d = cnt_q + 1'b1;
                    end
                end
                FILL_READY: begin
                    st_d = FILL_READY;
                end
                default: st_d = FILL_STALE;
            endcase
        end
    end

    assign ready = (st_q == FILL_READY);
endmodule

// File: rtl/gamma_table_mem.sv
module gamma_table_mem #(
    parameter int MEM_DEPTH = 2304,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int RD_PORTS  = 9
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [RD_PORTS*ADDR_W-1:0] rd_addr,
    output logic [RD_PORTS*DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        for (int p = 0; p < RD_PORTS; p++) begin
            rd_data[p*DATA_W +: DATA_W] <= mem[rd_addr[p*ADDR_W +: ADDR_W]];
        end
    end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
    import gamma_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int COMP_W = DEF_COMP_W,
    parameter int HOST_W = DEF_HOST_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_sel,
    input  logic [HOST_W-1:0]        host_wdata,
    input  logic [NUM_CH-1:0]        gamma_en,
    input  logic [NUM_CH-1:0]        pix_valid_in,
    input  logic [NUM_CH*COLOURS*COMP_W-1:0] pix_in,
    output logic [NUM_CH-1:0]        pix_valid_out,
    output logic [NUM_CH*COLOURS*COMP_W-1:0] pix_out,
    output logic [NUM_CH-1:0]        pix_err_out
);
    localparam int TBL_DEPTH = 1 << COMP_W;
    localparam int CH_SPAN   = COLOURS * TBL_DEPTH;
    localparam int MEM_DEPTH = NUM_CH * CH_SPAN;
    localparam int ADDR_W    = $clog2(MEM_DEPTH);
    localparam int PIX_W     = COLOURS * COMP_W;
    localparam int RD_PORTS  = NUM_CH * COLOURS;

    // Memory power state machine
    mem_pwr_e pwr_q, pwr_d;
    logic     mem_on, pwr_drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= MEM_OFF;
        else        pwr_q <= pwr_d;
    end

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            MEM_OFF: if (|gamma_en)  pwr_d = MEM_ON;
            MEM_ON:  if (!(|gamma_en)) pwr_d = MEM_OFF;
        endcase
    end

    assign mem_on   = (pwr_q == MEM_ON);
    assign pwr_drop = (pwr_d == MEM_OFF);

    // Host register port
    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [COMP_W-1:0] wr_data;

    gamma_host_port #(
        .MEM_DEPTH (MEM_DEPTH),
        .ADDR_W    (ADDR_W),
        .HOST_W    (HOST_W),
        .DATA_W    (COMP_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .mem_on     (mem_on),
        .wr_fire    (wr_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    // Shared table memory
    logic [RD_PORTS*ADDR_W-1:0] rd_addr;
    logic [RD_PORTS*COMP_W-1:0] rd_data;

    gamma_table_mem #(
        .MEM_DEPTH (MEM_DEPTH),
        .ADDR_W    (ADDR_W),
        .DATA_W    (COMP_W),
        .RD_PORTS  (RD_PORTS)
    ) u_mem (
        .clk     (clk),
        .wr_en   (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Per-channel fill tracking and pixel pipeline
    logic [NUM_CH-1:0] chan_ready;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic             vld_q, en_q, err_q;
        logic [PIX_W-1:0] pass_q;
        logic [PIX_W-1:0] lut_px;

        gamma_fill_tracker #(
            .ADDR_W  (ADDR_W),
            .CH_SPAN (CH_SPAN),
            .BASE    (c * CH_SPAN)
        ) u_fill (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_drop (pwr_drop),
            .wr_fire  (wr_fire),
            .wr_addr  (wr_addr),
            .ready    (chan_ready[c])
        );

        for (genvar k = 0; k < COLOURS; k++) begin : g_comp
            localparam int LSB  = (COLOURS - 1 - k) * COMP_W;
            localparam int PORT = c * COLOURS + k;
            assign rd_addr[PORT*ADDR_W +: ADDR_W] =
                ADDR_W'(c * CH_SPAN + k * TBL_DEPTH) +
                ADDR_W'(pix_in[c*PIX_W + LSB +: COMP_W]);
            assign lut_px[LSB +: COMP_W] = rd_data[PORT*COMP_W +: COMP_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                en_q   <= 1'b0;
                err_q  <= 1'b0;
                pass_q <= '0;
            end else begin
                vld_q  <= pix_valid_in[c];
                en_q   <= gamma_en[c];
                err_q  <= pix_valid_in[c] && gamma_en[c] && !chan_ready[c];
                pass_q <= pix_in[c*PIX_W +: PIX_W];
            end
        end

        assign pix_valid_out[c]           = vld_q;
        assign pix_err_out[c]             = err_q;
        assign pix_out[c*PIX_W +: PIX_W]  = en_q ? lut_px : pass_q;
    end
endmodule

// File: rtl/gamma_lut_checker.sv
module gamma_lut_checker #(
    parameter int NUM_CH = 3,
    parameter int PIX_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       gamma_en,
    input logic [NUM_CH-1:0]       pix_valid_in,
    input logic [NUM_CH*PIX_W-1:0] pix_in,
    input logic [NUM_CH-1:0]       pix_valid_out,
    input logic [NUM_CH*PIX_W-1:0] pix_out,
    input logic [NUM_CH-1:0]       pix_err_out
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pix_valid_in[c] |=> pix_valid_out[c]);

        assert_idle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !pix_valid_in[c] |=> !pix_valid_out[c]);

        assert_bypass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid_in[c] && !gamma_en[c]) |=>
                (pix_out[c*PIX_W +: PIX_W] == $past(pix_in[c*PIX_W +: PIX_W]))
                && !pix_err_out[c]);

        assert_err_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pix_err_out[c] |-> $past(pix_valid_in[c] && gamma_en[c]));

        assert_stale_after_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(gamma_en) == '0) && gamma_en[c] && pix_valid_in[c]) |=> pix_err_out[c]);
    end
endmodule

bind gamma_lut_top gamma_lut_checker #(
    .NUM_CH (NUM_CH),
    .PIX_W  (PIX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gamma_en      (gamma_en),
    .pix_valid_in  (pix_valid_in),
    .pix_in        (pix_in),
    .pix_valid_out (pix_valid_out),
    .pix_out       (pix_out),
    .pix_err_out   (pix_err_out)
);

// File: tb/gamma_lut_top_bench.sv
module gamma_lut_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 3;
    localparam int SPAN = 768;
    localparam int MEMD = 2304;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_sel = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [2:0]    gamma_en = '0;
    logic [2:0]    pix_valid_in = '0;
    logic [71:0]   pix_in = '0;
    logic [2:0]    pix_valid_out;
    logic [71:0]   pix_out;
    logic [2:0]    pix_err_out;

    logic [7:0] exp_mem [MEMD];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_top u_gamma_lut_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_sel      (host_sel),
        .host_wdata    (host_wdata),
        .gamma_en      (gamma_en),
        .pix_valid_in  (pix_valid_in),
        .pix_in        (pix_in),
        .pix_valid_out (pix_valid_out),
        .pix_out       (pix_out),
        .pix_err_out   (pix_err_out)
    );

    function automatic logic [7:0] pat(input int c, input int i, input int seed);
        return 8'((i * (7 + seed)) + c * 53 + 19 + seed * 61);
    endfunction

    function automatic logic [23:0] expect_px(input int c, input logic [7:0] r, g, b);
        if (!gamma_en[c]) return {r, g, b};
        return {exp_mem[c*SPAN + int'(r)], exp_mem[c*SPAN + 256 + int'(g)],
                exp_mem[c*SPAN + 512 + int'(b)]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic set_addr(input int a, input bit inc);
        host_write(1'b0, {inc, 15'(a)});
    endtask

    task automatic load_chan(input int c, input int n, input int seed, input bit upd);
        set_addr(c * SPAN, 1'b1);
        for (int i = 0; i < n; i++) begin
            host_write(1'b1, {8'h00, pat(c, i, seed)});
            if (upd) exp_mem[c*SPAN + i] = pat(c, i, seed);
        end
    endtask

    task automatic set_en(input logic [2:0] en);
        gamma_en = en;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_pix(input int c, input logic [7:0] r, g, b, input bit exp_err,
                            input string tag);
        logic [23:0] exp_px;
        exp_px = expect_px(c, r, g, b);
        pix_in[c*24 +: 24] = {r, g, b};
        pix_valid_in[c] = 1'b1;
        @(negedge clk);
        pix_valid_in[c] = 1'b0;
        check(pix_valid_out[c] == 1'b1, {tag, " valid"}, 32'(pix_valid_out[c]), 1);
        check(pix_err_out[c] == exp_err, {tag, " err"}, 32'(pix_err_out[c]), 32'(exp_err));
        if (!exp_err)
            check(pix_out[c*24 +: 24] == exp_px, {tag, " data"}, 32'(pix_out[c*24 +: 24]),
                  32'(exp_px));
    endtask

    task automatic t_reset;
        check(pix_valid_out == 3'b000, "R1 reset valid", 32'(pix_valid_out), 0);
        check(pix_err_out == 3'b000, "R1 reset err", 32'(pix_err_out), 0);
    endtask

    task automatic t_stale_start;
        set_en(3'b001);
        send_pix(0, 8'd3, 8'd4, 8'd5, 1'b1, "R1 R10 stale after reset");
    endtask

    task automatic t_load_ch0;
        load_chan(0, SPAN, 0, 1'b1);
        send_pix(0, 8'd0, 8'd0, 8'd0, 1'b0, "R2 R4 R7 zero pixel");
        send_pix(0, 8'd255, 8'd128, 8'd1, 1'b0, "R2 R7 mixed pixel");
        send_pix(0, 8'd17, 8'd200, 8'd99, 1'b0, "R7 third pixel");
    endtask

    task automatic t_independent;
        set_en(3'b011);
        send_pix(1, 8'd9, 8'd9, 8'd9, 1'b1, "R11 ch1 not ready");
        load_chan(1, SPAN, 1, 1'b1);
        send_pix(1, 8'd40, 8'd250, 8'd7, 1'b0, "R2 ch1 lookup");
        load_chan(2, SPAN - 1, 2, 1'b1);
        set_en(3'b111);
        send_pix(2, 8'd1, 8'd2, 8'd3, 1'b1, "R10 ch2 one short");
        host_write(1'b1, {8'h00, pat(2, SPAN - 1, 2)});
        exp_mem[2*SPAN + SPAN - 1] = pat(2, SPAN - 1, 2);
        send_pix(2, 8'd1, 8'd2, 8'd255, 1'b0, "R10 ch2 ready");
    endtask

    task automatic t_bypass_parallel;
        logic [23:0] e0, e1, e2;
        set_en(3'b101);
        send_pix(1, 8'h12, 8'h34, 8'h56, 1'b0, "R8 ch1 bypass");
        e0 = expect_px(0, 8'd10, 8'd20, 8'd30);
        e1 = expect_px(1, 8'd11, 8'd21, 8'd31);
        e2 = expect_px(2, 8'd12, 8'd22, 8'd32);
        pix_in = {24'({8'd12, 8'd22, 8'd32}), 24'({8'd11, 8'd21, 8'd31}),
                  24'({8'd10, 8'd20, 8'd30})};
        pix_valid_in = 3'b111;
        @(negedge clk);
        pix_valid_in = 3'b000;
        check(pix_valid_out == 3'b111, "R7 parallel valid", 32'(pix_valid_out), 7);
        check(pix_err_out == 3'b000, "R7 parallel err", 32'(pix_err_out), 0);
        check(pix_out[23:0] == e0, "R7 parallel ch0", 32'(pix_out[23:0]), 32'(e0));
        check(pix_out[47:24] == e1, "R8 parallel ch1", 32'(pix_out[47:24]), 32'(e1));
        check(pix_out[71:48] == e2, "R7 parallel ch2", 32'(pix_out[71:48]), 32'(e2));
        set_en(3'b111);
    endtask

    task automatic t_no_increment;
        set_addr(5, 1'b0);
        host_write(1'b1, 16'h00AA);
        host_write(1'b1, 16'h00BB);
        exp_mem[5] = 8'hBB;
        send_pix(0, 8'd5, 8'd0, 8'd0, 1'b0, "R3 R6 overwrite same entry");
        send_pix(0, 8'd6, 8'd0, 8'd0, 1'b0, "R6 neighbour untouched");
    endtask

    task automatic t_wrap;
        set_addr(MEMD - 1, 1'b1);
        host_write(1'b1, 16'h005C);
        host_write(1'b1, 16'h00C5);
        exp_mem[MEMD - 1] = 8'h5C;
        exp_mem[0] = 8'hC5;
        send_pix(2, 8'd0, 8'd0, 8'd255, 1'b0, "R5 last entry");
        send_pix(0, 8'd0, 8'd0, 8'd0, 1'b0, "R5 wrapped to zero");
        set_addr(3000, 1'b0);
        host_write(1'b1, 16'h003E);
        exp_mem[0] = 8'h3E;
        send_pix(0, 8'd0, 8'd1, 8'd2, 1'b0, "R3 out of range address");
    endtask

    task automatic t_power_down;
        set_en(3'b000);
        send_pix(0, 8'h77, 8'h88, 8'h99, 1'b0, "R8 bypass while off");
        load_chan(0, SPAN, 3, 1'b0);
        set_en(3'b001);
        send_pix(0, 8'd1, 8'd1, 8'd1, 1'b1, "R9 writes while off ignored");
        load_chan(0, SPAN, 3, 1'b1);
        send_pix(0, 8'd100, 8'd101, 8'd102, 1'b0, "R9 reloaded ch0");
        set_en(3'b011);
        send_pix(1, 8'd1, 8'd1, 8'd1, 1'b1, "R9 ch1 lost contents");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stale_start();
        t_load_ch0();
        t_independent();
        t_bypass_parallel();
        t_no_increment();
        t_wrap();
        t_power_down();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule